// File: doc/BRIEF.md
# MDIO Management Master with Host Registers

This block is a clause-22 management-bus master. A host reaches it through a small register port that selects one of two 16-bit registers. The first is a control word holding a PHY address, a register number, a clock-range code, a direction flag and a busy flag. The second is a data word. One control write starts a complete transaction. The block generates MDC from the system clock, shifts out one 64-bit frame on MDIO, and releases the line for the PHY's reply when the access is a read. On a read, the reply is stored in the data word. The host learns that the transaction has finished by polling the busy flag in the control word.

A control write with the busy flag clear starts no frame. Instead it produces a single MDC period with MDIO released, and the block then returns to idle. Software uses this to wake PHYs that stay in reset until MDC has toggled at least once.

The frame sequencer has three states. In `ST_IDLE`, a control write with bit 0 set goes to `ST_SHIFT`, and a control write with bit 0 clear goes to `ST_KICK`. `ST_SHIFT` returns to `ST_IDLE` on the falling MDC edge that ends bit 63. `ST_KICK` returns to `ST_IDLE` on its first falling MDC edge.

Top module: `mdio_master`

## Requirements
- R1: With `host_sel` = 0, `host_rdata` returns the control word. The PHY address sits at [15:11], the register number at [10:6], the clock-range code at [5:2] and the write flag at [1]. Bit [0] reads 1 while the controller is active and 0 otherwise. With `host_sel` = 1, `host_rdata` returns the data word. Every field is zero after reset.
- R2: When the controller is idle, a control write with bit 0 set starts a frame. Busy reads 1 from the following cycle for exactly 128·H cycles, where H is the MDC half period. After that, busy reads 0.
- R3: A write frame (bit 1 = 1) is sent MSB first, with a new bit on each MDC falling edge. It consists of 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then turnaround 10, then the 16 data bits. `mdio_oe` stays high for the whole frame.
- R4: A read frame (bit 1 = 0) uses opcode 10. `mdio_oe` is high for bits 0 to 45 and low from bit 46 (the turnaround) to the end of the frame.
- R5: During read bits 48 to 63, `mdio_i` is sampled on the MDC rising edge, MSB first. The 16-bit result is readable in the data word once busy has cleared.
- R6: The data word is captured into the frame when the transaction starts. Writes to the data word during a write frame do not change the bits sent.
- R7: The MDC half period is H = HALF_MIN·2^code in system clocks. Any code of NUM_CODES or above uses the slowest ratio, HALF_MIN·2^(NUM_CODES−1).
- R8: MDC is low while idle, and each frame starts with MDC low. MDIO and `mdio_oe` change only on edges where MDC goes low. While idle, `mdio_oe` is 0.
- R9: A control write while busy reads 1 is ignored. The stored fields and the transaction in progress are unchanged.
- R10: A control write with bit 0 clear stores the fields and produces exactly one MDC period (2·H cycles, MDC low first) with `mdio_oe` low. During that period busy reads 1, and the controller is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wdata | input | 16 | Register write value |
| host_rdata | output | 16 | Selected register value |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with HALF_MIN = 2 and NUM_CODES = 3. This gives half periods of 2, 4 and 8 clocks, so every legal code and the fall-back for codes 3 to 15 are exercised while a full frame takes at most 1024 cycles. With these values the bench can run several complete read and write frames, the single-period wake-up, writes issued while busy, and a data write in the middle of a frame, and still compare MDC, MDIO and the register values on every cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_KICK  = 2'd2
    } mdio_state_t;

    localparam int unsigned FRAME_BITS  = 64;
    localparam int unsigned IDX_W       = $clog2(FRAME_BITS);
    localparam int unsigned RELEASE_BIT = 46;
    localparam int unsigned DATA_BIT    = 48;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned FIELD_W     = 5;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == half - CNT_W'(1));
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);                                            // R8
    AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (half != '0));                                     // R7

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              kick,
    input  logic              is_wr,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regn,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_BIT);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_BIT);

    mdio_state_t            state_q, state_d;
    logic [FRAME_BITS-1:0]  sreg_q;
    logic [FRAME_BITS-1:0]  frame;
    logic [IDX_W-1:0]       idx_q;
    logic                   wr_q;
    logic [WORD_W-1:0]      rsh_q;
    logic                   last_fall;

    assign frame = {{32{1'b1}}, 2'b01,
                    is_wr ? 2'b01 : 2'b10,
                    phy, regn,
                    is_wr ? 2'b10 : 2'b00,
                    is_wr ? wdata : {WORD_W{1'b0}}};

    assign last_fall = fall_stb && (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)     state_d = ST_SHIFT;
                else if (kick) state_d = ST_KICK;
            end
            ST_SHIFT: if (last_fall) state_d = ST_IDLE;
            ST_KICK:  if (fall_stb)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
            wr_q   <= 1'b0;
            rsh_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                sreg_q <= frame;
                idx_q  <= '0;
                wr_q   <= is_wr;
            end else if (state_q == ST_SHIFT && fall_stb) begin
                sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
                idx_q  <= idx_q + IDX_W'(1);
            end
            if (state_q == ST_SHIFT && rise_stb && !wr_q && idx_q >= DAT_IDX)
                rsh_q <= {rsh_q[WORD_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        run     = (state_q != ST_IDLE);
        done    = (state_q == ST_SHIFT) && last_fall;
        rd_data = rsh_q;
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_SHIFT: begin
                mdio_o  = sreg_q[FRAME_BITS-1];
                mdio_oe = wr_q || (idx_q < REL_IDX);
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> run);                    // R2
    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));                            // R2

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned HALF_MIN  = 2,
    parameter int unsigned NUM_CODES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int unsigned HALF_MAX = HALF_MIN << (NUM_CODES - 1);
    localparam int unsigned CNT_W    = $clog2(HALF_MAX + 1);

    logic [FIELD_W-1:0] phy_q, reg_q;
    logic [3:0]         code_q;
    logic               wr_q;
    logic [WORD_W-1:0]  data_q;
    logic               busy, done, ctrl_wr, accept, start, kick;
    logic               rise_stb, fall_stb;
    logic [WORD_W-1:0]  rd_data;
    logic [CNT_W-1:0]   half;

    function automatic logic [CNT_W-1:0] half_of(input logic [3:0] code);
        int unsigned sel;
        sel = {28'd0, code};
        if (sel >= NUM_CODES) sel = NUM_CODES - 1;
        return CNT_W'(HALF_MIN << sel);
    endfunction

    assign half    = half_of(code_q);
    assign ctrl_wr = host_wr && !host_sel;
    assign accept  = ctrl_wr && !busy;
    assign start   = accept && host_wdata[0];
    assign kick    = accept && !host_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q  <= '0;
            reg_q  <= '0;
            code_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            phy_q  <= host_wdata[15:11];
            reg_q  <= host_wdata[10:6];
            code_q <= host_wdata[5:2];
            wr_q   <= host_wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (done && !wr_q)         data_q <= rd_data;
        else if (host_wr && host_sel)   data_q <= host_wdata;
    end

    assign host_rdata = host_sel ? data_q : {phy_q, reg_q, code_q, wr_q, busy};

    mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half     (half),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kick     (kick),
        .is_wr    (host_wdata[1]),
        .phy      (host_wdata[15:11]),
        .regn     (host_wdata[10:6]),
        .wdata    (data_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .run      (busy),
        .done     (done),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable({phy_q, reg_q, code_q, wr_q}));   // R9
    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
    AST_KICK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !mdio_oe);                                             // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));                                  // R8

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    localparam int HALF_MIN  = 2;
    localparam int NUM_CODES = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    mdio_master #(.HALF_MIN(HALF_MIN), .NUM_CODES(NUM_CODES)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit          m_active = 0, m_wr = 0, m_kick = 0;
    int          m_p = 0, m_h = 1, m_len = 1;
    logic [63:0] m_frame = '0;
    logic [15:0] m_ctrl = '0, m_data = '0, phy_val = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_active = 0; m_ctrl = '0; m_data = '0;
        end else begin
            if (m_active) begin
                m_p++;
                if (m_p == m_len * 2 * m_h) begin
                    m_active = 0;
                    if (!m_kick && !m_wr) m_data = phy_val;
                end
            end else if (host_wr && !host_sel) begin
                int code;
                m_ctrl = {host_wdata[15:1], 1'b0};
                m_wr   = host_wdata[1];
                m_kick = !host_wdata[0];
                code   = int'(host_wdata[5:2]);
                if (code >= NUM_CODES) code = NUM_CODES - 1;
                m_h    = HALF_MIN << code;
                m_len  = m_kick ? 1 : 64;
                m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10,
                           host_wdata[15:11], host_wdata[10:6],
                           m_wr ? 2'b10 : 2'b00, m_wr ? m_data : 16'h0};
                m_active = 1;
                m_p = 0;
            end
            if (host_wr && host_sel) m_data = host_wdata;
        end
    end

    // compare and PHY drive away from the active edge
    always @(negedge clk) begin
        logic e_mdc, e_oe, e_out;
        logic [15:0] e_rd;
        int bitn;
        bitn  = m_active ? m_p / (2 * m_h) : 0;
        e_mdc = m_active ? ((m_p % (2 * m_h)) >= m_h) : 1'b0;
        e_oe  = m_active && !m_kick && (m_wr || bitn < 46);
        e_out = m_frame[63 - bitn];
        e_rd  = host_sel ? m_data : {m_ctrl[15:1], m_active};
        if (rst_n) begin
            vectors++;
            if (mdc !== e_mdc) begin
                errors++;
                $display("FAIL R7 mdc at %0t actual=%b expected=%b", $time, mdc, e_mdc);
            end
            vectors++;
            if (mdio_oe !== e_oe) begin
                errors++;
                $display("FAIL R4 mdio_oe at %0t actual=%b expected=%b", $time, mdio_oe, e_oe);
            end
            if (e_oe) begin
                vectors++;
                if (mdio_o !== e_out) begin
                    errors++;
                    $display("FAIL R3 mdio_o bit %0d at %0t actual=%b expected=%b",
                             bitn, $time, mdio_o, e_out);
                end
            end
            vectors++;
            if (host_rdata !== e_rd) begin
                errors++;
                $display("FAIL %s host_rdata at %0t actual=%h expected=%h",
                         host_sel ? "R5" : "R1", $time, host_rdata, e_rd);
            end
        end
        if (m_active && !m_kick && !m_wr && bitn >= 48)
            mdio_i <= phy_val[15 - (bitn - 48)];
        else
            mdio_i <= 1'b1;
    end

    task automatic host_write(input logic sel, input logic [15:0] val);
        @(posedge clk); #2;
        host_wr = 1'b1; host_sel = sel; host_wdata = val;
        @(posedge clk); #2;
        host_wr = 1'b0; host_sel = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #2;
        while (m_active) begin @(posedge clk); #2; end
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic peek_data();
        @(posedge clk); #2;
        host_sel = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        host_sel = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input logic [4:0] p, input logic [4:0] r,
                                        input logic [3:0] c, input logic w, input logic b);
        return {p, r, c, w, b};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);   // R1 reset state compared each cycle

        // R3 R6 R9: write frame, code 0, data changed and control rewritten mid-frame
        host_write(1'b1, 16'hA5C3);
        host_write(1'b0, ctl(5'h13, 5'h0A, 4'd0, 1'b1, 1'b1));
        repeat (40) @(posedge clk);
        host_write(1'b1, 16'h1234);                               // R6
        host_write(1'b0, ctl(5'h01, 5'h02, 4'd2, 1'b0, 1'b1));    // R9
        wait_idle();
        peek_data();

        // R4 R5: read frame, code 1
        phy_val = 16'h8E71;
        host_write(1'b0, ctl(5'h1F, 5'h01, 4'd1, 1'b0, 1'b1));
        wait_idle();
        peek_data();

        // R7: slowest legal code, read
        phy_val = 16'h0001;
        host_write(1'b0, ctl(5'h00, 5'h1F, 4'd2, 1'b0, 1'b1));
        wait_idle();
        peek_data();

        // R7: out-of-table code falls back to the slowest ratio, write
        host_write(1'b1, 16'hFFFE);
        host_write(1'b0, ctl(5'h0A, 5'h15, 4'd9, 1'b1, 1'b1));
        wait_idle();

        // R10: all-zero control write gives one MDC period, then idle
        host_write(1'b0, 16'h0000);
        wait_idle();
        // R10: bit 0 clear with a slow code, fields kept
        host_write(1'b0, ctl(5'h07, 5'h03, 4'd2, 1'b1, 1'b0));
        repeat (3) @(posedge clk);
        host_write(1'b0, ctl(5'h07, 5'h03, 4'd0, 1'b1, 1'b1));   // R9 during kick
        wait_idle();

        // R2: back-to-back read frames
        phy_val = 16'h5A0F;
        host_write(1'b0, ctl(5'h11, 5'h11, 4'd0, 1'b0, 1'b1));
        @(posedge clk); #2;
        while (m_active) begin @(posedge clk); #2; end
        phy_val = 16'hC3C3;
        host_write(1'b0, ctl(5'h12, 5'h04, 4'd0, 1'b0, 1'b1));
        wait_idle();
        peek_data();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule